// File: doc/BRIEF.md
# Sequential Shift-Add Mantissa Multiplier

This block forms the product of two normalized floating-point numbers held as sign, exponent and a wide fixed-point mantissa. The mantissa is `NUM_WORDS` words of `WORD_W` bits. Its lowest `GUARD_BITS` bits are guard and round positions, and its leading one sits at bit `LEAD_BIT`, which is the value 1.0. A one-cycle `start` pulse captures both operands. The block then walks the multiplier from its least significant bit upward, one bit per clock. At each bit it shifts a partial-product accumulator right by one place and adds the multiplicand when the bit is set. Every bit that falls off the bottom of the accumulator is folded into a sticky flag.

Two shortcuts keep the cycle count down. A multiplier word that is entirely zero is consumed in a single cycle. In the lowest word this costs no shift at all, because the accumulator is still empty. In any higher word the accumulator drops by a whole word, and that word is ORed into sticky. Scanning of the top word ends as soon as no set bit remains above the bit pointer.

A raw product in [2,4) is shifted right once more and its exponent is bumped by one. The block then presents the mantissa, sticky, exponent sum and sign XOR together with a one-cycle `done` pulse. Rounding, special operands and exponent range checks belong to the surrounding datapath.

Control is a four-state machine:
- `ST_IDLE` waits for `start` and loads the operands (transition IDLE→WORD).
- `ST_WORD` inspects the current multiplier word. A zero word is skipped and the machine stays in WORD for the next word (WORD→WORD). A nonzero word positions the bit pointer (WORD→STEP). The pointer goes to bit `GUARD_BITS` in the lowest word and to bit 0 elsewhere.
- `ST_STEP` performs one shift-add per cycle. At the end of a lower word it moves to the next word (STEP→WORD). In the top word, once no higher bit is set, it finishes (STEP→NORM).
- `ST_NORM` post-normalizes, registers the result and raises `done` (NORM→IDLE).

Top module: `mant_shift_mul`

## Requirements
- R1: After reset, `done` is 0 and `prod_mant`, `prod_sticky`, `prod_exp` and `prod_sign` are all 0.
- R2: For normalized operands X and Y (leading one at bit `LEAD_BIT`, no bits above it), `prod_mant` equals floor(X·Y' / 2^S). Y' is Y with its `GUARD_BITS` lowest bits cleared. S is `LEAD_BIT` when X·Y' < 2^(2·LEAD_BIT+1), and `LEAD_BIT`+1 otherwise.
- R3: `prod_sticky` is 1 exactly when X·Y' mod 2^S is nonzero, with S as in R2.
- R4: When the raw product reaches 2.0 (X·Y' ≥ 2^(2·LEAD_BIT+1)), the result is shifted right one extra place and `prod_exp` gains one. Every result has bit `LEAD_BIT` set and no bit above it.
- R5: `prod_exp` is `a_exp` + `b_exp` (+1 per R4), modulo 2^`EXP_W`, and `prod_sign` is `a_sign` XOR `b_sign`.
- R6: An all-zero multiplier word costs one cycle. With the default parameters, `done` is high on the clock edge numbered 3 + s0 + s1 + s2 + 1 after the edge that accepts `start`. Here s0 is 30 if the lowest multiplier word is nonzero and 0 if it is zero. s1 is 32 if the middle word is nonzero and 0 if it is zero.
- R7: Set bits in the multiplier's guard positions (bits below `GUARD_BITS`) do not change the product or the sticky flag.
- R8: In the top multiplier word, stepping stops after the highest set bit, so s2 is that bit's index within the word plus one (30 for normalized defaults).
- R9: `done` is high for exactly one cycle per accepted `start`. A `start` that arrives while an operation is in progress is ignored: it changes neither the result nor the latency, and it causes no extra `done`.
- R10: The result outputs keep their values from one `done` pulse until the next, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept operands and begin, honoured only when idle |
| a_sign | input | 1 | Sign of the multiplicand |
| a_exp | input | EXP_W | Exponent of the multiplicand |
| a_mant | input | NUM_WORDS·WORD_W | Mantissa of the multiplicand |
| b_sign | input | 1 | Sign of the multiplier |
| b_exp | input | EXP_W | Exponent of the multiplier |
| b_mant | input | NUM_WORDS·WORD_W | Mantissa of the multiplier |
| prod_mant | output | NUM_WORDS·WORD_W | Normalized product mantissa |
| prod_sticky | output | 1 | OR of every product bit discarded below the mantissa |
| prod_exp | output | EXP_W | Exponent sum, including the normalization bump |
| prod_sign | output | 1 | Product sign |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The hardest case to reach from the ports is a whole-word drop that discards nonzero accumulator bits into sticky. This needs a multiplier whose lowest word is nonzero, so that the accumulator has content, followed by an all-zero middle word. The bench builds such multipliers directly, and its random loop also clears the low word, the middle word or both. It pairs these multipliers with multiplicands that have dense low bits, so the dropped word is rarely zero. It then checks sticky and the exact cycle count, which separates the one-cycle skip from a bit-by-bit scan. Near-2.0 multiplicands force the post-normalization path.

// File: rtl/mant_mul_pkg.sv
`timescale 1ns/1ps
package mant_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WORD,
        ST_STEP,
        ST_NORM
    } mul_state_e;

    typedef enum logic [1:0] {
        ACC_KEEP,
        ACC_LOAD,
        ACC_STEP,
        ACC_DROPW
    } acc_op_e;

endpackage

// File: rtl/mant_mul_wordsel.sv
`timescale 1ns/1ps
// Holds the captured multiplier and exposes the word and bit under scan.
module mant_mul_wordsel #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load,
    input  logic [NUM_WORDS*WORD_W-1:0]           y_in,
    input  logic [$clog2(NUM_WORDS)-1:0]          word_sel,
    input  logic [$clog2(WORD_W)-1:0]             bit_sel,
    output logic                                  cur_zero,
    output logic                                  cur_bit,
    output logic                                  bits_above
);
    localparam int MANT_W = NUM_WORDS * WORD_W;

    logic [MANT_W-1:0] y_q;
    logic [WORD_W-1:0] words [NUM_WORDS];
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] upper;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q <= '0;
        end else if (load) begin
            y_q <= y_in;
        end
    end

    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slice
            assign words[g] = y_q[g*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        cur_word   = words[word_sel];
        cur_zero   = (cur_word == '0);
        cur_bit    = cur_word[bit_sel];
        upper      = (cur_word >> bit_sel) >> 1;
        bits_above = (upper != '0);
    end

endmodule

// File: rtl/mant_mul_accum.sv
`timescale 1ns/1ps
// Partial-product accumulator with sticky collection and post-normalization.
module mant_mul_accum
    import mant_mul_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    parameter int LEAD_BIT  = 93
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  acc_op_e                       op,
    input  logic                          add_en,
    input  logic [NUM_WORDS*WORD_W-1:0]   x_in,
    output logic [NUM_WORDS*WORD_W-1:0]   norm_mant,
    output logic                          norm_sticky,
    output logic                          norm_bump
);
    localparam int MANT_W = NUM_WORDS * WORD_W;
    localparam int ACC_W  = MANT_W + 1;

    logic [MANT_W-1:0] x_q;
    logic [ACC_W-1:0]  acc_q;
    logic              sticky_q;
    logic [ACC_W-1:0]  addend;

    assign addend = add_en ? {1'b0, x_q} : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q      <= '0;
            acc_q    <= '0;
            sticky_q <= 1'b0;
        end else begin
            unique case (op)
                ACC_LOAD: begin
                    x_q      <= x_in;
                    acc_q    <= '0;
                    sticky_q <= 1'b0;
                end
                ACC_STEP: begin
                    acc_q    <= (acc_q >> 1) + addend;
                    sticky_q <= sticky_q | acc_q[0];
                end
                ACC_DROPW: begin
                    acc_q    <= acc_q >> WORD_W;
                    sticky_q <= sticky_q | (|acc_q[WORD_W-1:0]);
                end
                ACC_KEEP: begin
                end
            endcase
        end
    end

    generate
        if (LEAD_BIT + 1 < ACC_W) begin : g_norm
            always_comb begin
                norm_bump   = acc_q[LEAD_BIT+1];
                norm_mant   = norm_bump ? acc_q[MANT_W:1] : acc_q[MANT_W-1:0];
                norm_sticky = sticky_q | (norm_bump & acc_q[0]);
            end
        end else begin : g_norm_top
            always_comb begin
                norm_bump   = acc_q[ACC_W-1];
                norm_mant   = norm_bump ? acc_q[MANT_W:1] : acc_q[MANT_W-1:0];
                norm_sticky = sticky_q | (norm_bump & acc_q[0]);
            end
        end
    endgenerate

endmodule

// File: rtl/mant_mul_ctrl.sv
`timescale 1ns/1ps
// Sequencer: word inspection, bit stepping and the finishing state.
module mant_mul_ctrl
    import mant_mul_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 3,
    parameter int GUARD_BITS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              cur_zero,
    input  logic                              bits_above,
    output mul_state_e                        state,
    output logic [$clog2(NUM_WORDS)-1:0]      word_sel,
    output logic [$clog2(WORD_W)-1:0]         bit_sel,
    output logic                              load,
    output acc_op_e                           acc_op
);
    localparam int WSEL_W = $clog2(NUM_WORDS);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam logic [WSEL_W-1:0] TOP_WORD  = WSEL_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0]  FIRST_IDX = IDX_W'(GUARD_BITS);

    mul_state_e          state_q, state_d;
    logic [WSEL_W-1:0]   word_q, word_d;
    logic [IDX_W-1:0]    idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_WORD;
                    word_d  = '0;
                    idx_d   = '0;
                end
            end
            ST_WORD: begin
                if (cur_zero) begin
                    if (word_q == TOP_WORD) begin
                        state_d = ST_NORM;
                    end else begin
                        word_d = word_q + 1'b1;
                    end
                end else begin
                    state_d = ST_STEP;
                    idx_d   = (word_q == '0) ? FIRST_IDX : '0;
                end
            end
            ST_STEP: begin
                if (word_q == TOP_WORD && !bits_above) begin
                    state_d = ST_NORM;
                end else if (idx_q == LAST_IDX) begin
                    state_d = ST_WORD;
                    word_d  = word_q + 1'b1;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_NORM: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        load   = 1'b0;
        acc_op = ACC_KEEP;
        unique case (state_q)
            ST_IDLE: begin
                load   = start;
                acc_op = start ? ACC_LOAD : ACC_KEEP;
            end
            ST_WORD: begin
                acc_op = (cur_zero && word_q != '0) ? ACC_DROPW : ACC_KEEP;
            end
            ST_STEP: begin
                acc_op = ACC_STEP;
            end
            ST_NORM: begin
                acc_op = ACC_KEEP;
            end
        endcase
    end

    assign state    = state_q;
    assign word_sel = word_q;
    assign bit_sel  = idx_q;

endmodule

// File: rtl/mant_shift_mul.sv
`timescale 1ns/1ps
module mant_shift_mul
    import mant_mul_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 3,
    parameter int GUARD_BITS = 2,
    parameter int LEAD_BIT   = 93,
    parameter int EXP_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          a_sign,
    input  logic [EXP_W-1:0]              a_exp,
    input  logic [NUM_WORDS*WORD_W-1:0]   a_mant,
    input  logic                          b_sign,
    input  logic [EXP_W-1:0]              b_exp,
    input  logic [NUM_WORDS*WORD_W-1:0]   b_mant,
    output logic [NUM_WORDS*WORD_W-1:0]   prod_mant,
    output logic                          prod_sticky,
    output logic [EXP_W-1:0]              prod_exp,
    output logic                          prod_sign,
    output logic                          done
);
    localparam int MANT_W = NUM_WORDS * WORD_W;
    localparam int WSEL_W = $clog2(NUM_WORDS);
    localparam int IDX_W  = $clog2(WORD_W);

    mul_state_e          state;
    acc_op_e             acc_op;
    logic                load;
    logic [WSEL_W-1:0]   word_sel;
    logic [IDX_W-1:0]    bit_sel;
    logic                cur_zero;
    logic                cur_bit;
    logic                bits_above;
    logic [MANT_W-1:0]   norm_mant;
    logic                norm_sticky;
    logic                norm_bump;
    logic [EXP_W-1:0]    exp_sum_q;
    logic                sign_q;

    mant_mul_ctrl #(
        .WORD_W     (WORD_W),
        .NUM_WORDS  (NUM_WORDS),
        .GUARD_BITS (GUARD_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cur_zero   (cur_zero),
        .bits_above (bits_above),
        .state      (state),
        .word_sel   (word_sel),
        .bit_sel    (bit_sel),
        .load       (load),
        .acc_op     (acc_op)
    );

    mant_mul_wordsel #(
        .WORD_W     (WORD_W),
        .NUM_WORDS  (NUM_WORDS)
    ) u_wordsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .y_in       (b_mant),
        .word_sel   (word_sel),
        .bit_sel    (bit_sel),
        .cur_zero   (cur_zero),
        .cur_bit    (cur_bit),
        .bits_above (bits_above)
    );

    mant_mul_accum #(
        .WORD_W     (WORD_W),
        .NUM_WORDS  (NUM_WORDS),
        .LEAD_BIT   (LEAD_BIT)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (acc_op),
        .add_en      (cur_bit),
        .x_in        (a_mant),
        .norm_mant   (norm_mant),
        .norm_sticky (norm_sticky),
        .norm_bump   (norm_bump)
    );

    // Operand side-band captured on acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_sum_q <= '0;
            sign_q    <= 1'b0;
        end else if (load) begin
            exp_sum_q <= a_exp + b_exp;
            sign_q    <= a_sign ^ b_sign;
        end
    end

    // Result registers and completion pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_mant   <= '0;
            prod_sticky <= 1'b0;
            prod_exp    <= '0;
            prod_sign   <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_NORM) begin
                prod_mant   <= norm_mant;
                prod_sticky <= norm_sticky;
                prod_exp    <= exp_sum_q + EXP_W'(norm_bump);
                prod_sign   <= sign_q;
                done        <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mant_shift_mul_chk.sv
`timescale 1ns/1ps
module mant_shift_mul_chk
    import mant_mul_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 3,
    parameter int LEAD_BIT   = 93,
    parameter int EXP_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          a_sign,
    input  logic [EXP_W-1:0]              a_exp,
    input  logic                          b_sign,
    input  logic [EXP_W-1:0]              b_exp,
    input  mul_state_e                    state,
    input  logic                          cur_zero,
    input  logic [$clog2(NUM_WORDS)-1:0]  word_sel,
    input  logic [NUM_WORDS*WORD_W-1:0]   prod_mant,
    input  logic                          prod_sticky,
    input  logic [EXP_W-1:0]              prod_exp,
    input  logic                          prod_sign,
    input  logic                          done
);
    localparam int WSEL_W = $clog2(NUM_WORDS);
    localparam logic [WSEL_W-1:0] TOP_WORD = WSEL_W'(NUM_WORDS - 1);

    logic [EXP_W-1:0] cap_sum;
    logic             cap_sign;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sum  <= '0;
            cap_sign <= 1'b0;
        end else if (start && state == ST_IDLE) begin
            cap_sum  <= a_exp + b_exp;
            cap_sign <= a_sign ^ b_sign;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_NORM_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM) |=> done); // R9
    AST_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod_mant[LEAD_BIT] && ((prod_mant >> (LEAD_BIT + 1)) == '0))); // R4
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod_sign == cap_sign)); // R5
    AST_EXP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((prod_exp == cap_sum) || (prod_exp == cap_sum + 1'b1))); // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_mant) && $stable(prod_sticky) && $stable(prod_exp) && $stable(prod_sign))); // R10
    AST_ZERO_WORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WORD && cur_zero && word_sel != TOP_WORD) |=> (state == ST_WORD)); // R6

endmodule

bind mant_shift_mul mant_shift_mul_chk #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .LEAD_BIT  (LEAD_BIT),
    .EXP_W     (EXP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .a_sign      (a_sign),
    .a_exp       (a_exp),
    .b_sign      (b_sign),
    .b_exp       (b_exp),
    .state       (state),
    .cur_zero    (cur_zero),
    .word_sel    (word_sel),
    .prod_mant   (prod_mant),
    .prod_sticky (prod_sticky),
    .prod_exp    (prod_exp),
    .prod_sign   (prod_sign),
    .done        (done)
);

// File: tb/mant_shift_mul_test.sv
`timescale 1ns/1ps
module mant_shift_mul_test;
    localparam int WW = 32;
    localparam int NW = 3;
    localparam int GB = 2;
    localparam int L  = 93;
    localparam int EW = 16;
    localparam int MW = WW * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          a_sign = 1'b0, b_sign = 1'b0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic [MW-1:0] a_mant = '0, b_mant = '0;
    logic [MW-1:0] prod_mant;
    logic          prod_sticky;
    logic [EW-1:0] prod_exp;
    logic          prod_sign;
    logic          done;

    int nchk = 0;
    int nerr = 0;

    logic [MW-1:0] last_mant;
    logic          last_sticky;
    logic [EW-1:0] last_exp;
    logic          last_sign;

    always #2 clk = ~clk;

    mant_shift_mul #(.WORD_W(WW), .NUM_WORDS(NW), .GUARD_BITS(GB), .LEAD_BIT(L), .EXP_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .prod_mant(prod_mant), .prod_sticky(prod_sticky), .prod_exp(prod_exp),
        .prod_sign(prod_sign), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [MW:0] act, input logic [MW:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [MW-1:0] norm_rand(input int dummy);
        logic [MW-1:0] v;
        logic [MW-1:0] lowmask;
        v = {$urandom(), $urandom(), $urandom()};
        lowmask = ({MW{1'b1}} >> (MW - L));
        return (v & lowmask) | (MW'(1) << L) | MW'(dummy & 0);
    endfunction

    function automatic int exp_cycles(input logic [MW-1:0] y);
        int cyc;
        int hi;
        cyc = NW + 1;
        if (y[WW-1:0] != '0) cyc += WW - GB;
        for (int w = 1; w < NW - 1; w++)
            if (y[w*WW +: WW] != '0) cyc += WW;
        hi = -1;
        for (int b = 0; b < WW; b++)
            if (y[(NW-1)*WW + b]) hi = b;
        cyc += hi + 1;
        return cyc;
    endfunction

    // Runs one operation; optionally pokes start mid-run with other operands.
    task automatic run_op(input logic [MW-1:0] x, input logic [MW-1:0] y,
                          input logic xs, input logic ys,
                          input logic [EW-1:0] xe, input logic [EW-1:0] ye,
                          input bit poke, input string tag);
        logic [2*MW-1:0] prod;
        logic [2*MW-1:0] mask;
        logic [MW-1:0]   ym;
        logic [MW-1:0]   mant_e;
        logic            st_e;
        logic            bump;
        logic [EW-1:0]   exp_e;
        int              sh;
        int              cnt;
        int              cyc_e;
        ym    = y & ~(MW'((1 << GB) - 1));
        prod  = {{MW{1'b0}}, x} * {{MW{1'b0}}, ym};
        bump  = prod[2*L+1];
        sh    = bump ? L + 1 : L;
        mant_e = MW'(prod >> sh);
        mask  = {(2*MW){1'b1}} >> (2*MW - sh);
        st_e  = |(prod & mask);
        exp_e = xe + ye + EW'(bump);
        cyc_e = exp_cycles(y);

        a_mant = x; b_mant = y; a_sign = xs; b_sign = ys; a_exp = xe; b_exp = ye;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 500) begin
            @(posedge clk); #1;
            cnt++;
            if (poke && cnt == 5) begin
                start = 1'b1;
                a_mant = ~x; b_mant = {1'b0, {(MW-1){1'b1}}};
                a_exp = ~xe; b_sign = ~ys;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(done, "R9", {tag, " done seen"}, MW'(done), 1);
        chk(cnt == cyc_e, "R6 R8", {tag, " latency"}, (MW+1)'(cnt), (MW+1)'(cyc_e));
        chk(prod_mant == mant_e, "R2 R4", {tag, " mantissa"}, {1'b0, prod_mant}, {1'b0, mant_e});
        chk(prod_sticky == st_e, "R3", {tag, " sticky"}, (MW+1)'(prod_sticky), (MW+1)'(st_e));
        chk(prod_exp == exp_e, "R5 R4", {tag, " exponent"}, (MW+1)'(prod_exp), (MW+1)'(exp_e));
        chk(prod_sign == (xs ^ ys), "R5", {tag, " sign"}, (MW+1)'(prod_sign), (MW+1)'(xs ^ ys));
        @(posedge clk); #1;
        chk(!done, "R9", {tag, " done one cycle"}, (MW+1)'(done), 0);
        last_mant = mant_e; last_sticky = st_e; last_exp = exp_e; last_sign = xs ^ ys;
    endtask

    task automatic t_reset();
        chk(!done, "R1", "reset done", (MW+1)'(done), 0);
        chk(prod_mant == '0 && !prod_sticky && prod_exp == '0 && !prod_sign, "R1",
            "reset outputs", {1'b0, prod_mant}, 0);
    endtask

    task automatic t_unit();
        logic [MW-1:0] one;
        one = MW'(1) << L;
        run_op(one, one, 1'b0, 1'b1, 16'h0003, 16'hfffe, 1'b0, "R2 unit");
    endtask

    task automatic t_bump();
        logic [MW-1:0] big;
        big = ({MW{1'b1}} >> (MW - L - 1)) & ~(MW'((1 << GB) - 1));
        run_op(big, big, 1'b1, 1'b1, 16'h7fff, 16'h0001, 1'b0, "R4 near-two");
    endtask

    task automatic t_mid_zero();
        logic [MW-1:0] x;
        logic [MW-1:0] y;
        x = (MW'(1) << L) | {{(MW-WW){1'b0}}, 32'hffff_ffff} | (MW'(32'h8000_0001) << WW);
        y = (MW'(1) << L) | (MW'(1) << (L - 7)) | MW'(32'h8000_0004);
        run_op(x, y, 1'b0, 1'b0, 16'h0010, 16'h0020, 1'b0, "R3 R6 middle-skip");
    endtask

    task automatic t_guard();
        logic [MW-1:0] x;
        logic [MW-1:0] y;
        x = norm_rand(0);
        y = norm_rand(0) & ~(MW'((1 << GB) - 1));
        y[WW-1:GB] = '0;
        y[0] = 1'b1;
        run_op(x, y, 1'b1, 1'b0, 16'h0100, 16'h0200, 1'b0, "R7 guard-set");
        y[0] = 1'b0;
        y[1] = 1'b1;
        run_op(x, y, 1'b1, 1'b0, 16'h0100, 16'h0200, 1'b0, "R7 guard-set-b");
    endtask

    task automatic t_busy();
        int seen;
        run_op(norm_rand(0), norm_rand(0), 1'b0, 1'b1, 16'h1234, 16'h0042, 1'b1, "R9 busy-start");
        seen = 0;
        for (int i = 0; i < 120; i++) begin
            @(posedge clk); #1;
            if (done) seen++;
        end
        chk(seen == 0, "R9", "no extra done", (MW+1)'(seen), 0);
    endtask

    task automatic t_hold();
        a_mant = ~a_mant; b_mant = norm_rand(0); a_exp = 16'h5555; b_sign = ~b_sign;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
        end
        chk(prod_mant == last_mant && prod_sticky == last_sticky, "R10", "mantissa held",
            {1'b0, prod_mant}, {1'b0, last_mant});
        chk(prod_exp == last_exp && prod_sign == last_sign, "R10", "exp/sign held",
            (MW+1)'(prod_exp), (MW+1)'(last_exp));
    endtask

    task automatic t_random();
        logic [MW-1:0] x;
        logic [MW-1:0] y;
        for (int i = 0; i < 24; i++) begin
            x = norm_rand(0);
            y = norm_rand(0) & ~(MW'((1 << GB) - 1));
            if (i % 4 == 1 || i % 4 == 3) y[WW-1:0] = '0;
            if (i % 4 == 2 || i % 4 == 3) y[2*WW-1:WW] = '0;
            run_op(x, y, 1'($urandom()), 1'($urandom()), 16'($urandom()), 16'($urandom()),
                   1'b0, "R2 R3 random");
        end
    endtask

    initial begin
        #(200000 * 4);
        nerr++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c));
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_unit();
        t_bump();
        t_mid_zero();
        t_guard();
        t_busy();
        t_hold();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule